// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Unit

This block counts hardware events for performance monitoring. It has five 48-bit counters. Two are general counters, each with a plain enable bit. Three are fixed counters, and each of those has a small control field. The field decides whether events count while the processor runs at ring 0, at a ring above 0, at both, or not at all. A single global enable register gates all five counters, and a counter advances only when its global bit and its local qualifier are both set. Every cycle, each counter receives a one-bit event pulse together with the current two-bit privilege ring.

When a counter passes its maximum value it rolls over to zero and sets a sticky overflow flag in a status register. If that counter's interrupt bit is set, the block also raises a single-cycle interrupt request. The status register has one more sticky flag, which records that a control register changed value. Software clears these flags by writing ones to a separate clear register. Registers are written through one write port and read through a combinational read port.

Top module: `pmu_counter_unit`

## Requirements
- R1: After a synchronous active-low reset, every counter, control register and status bit reads 0, and `irq_o` is 0.
- R2: The fixed control register (address 5) holds one 4-bit field per fixed counter, with fixed counter k at bits [4k+3:4k]. Field bit 0 allows counting at ring 0, and field bit 1 allows counting at rings 1 to 3. The value 00 stops the counter and 11 counts at every ring. Field bit 3 is the interrupt enable, and bit 2 is stored and read back.
- R3: The general control register (address 6) uses bit k to enable general counter k and bit 2+k to enable its interrupt. Privilege has no effect on these counters.
- R4: The global enable register (address 7) uses bits 0 and 1 for general counters 0 and 1, and bits 32, 33 and 34 for fixed counters 0, 1 and 2. Its other bits read as zero. A counter increments on an event only when its global bit and its local qualifier are both true, and otherwise it holds its value.
- R5: Counters are 48 bits wide and read at addresses 0 to 4 (general 0, general 1, fixed 0, fixed 1, fixed 2), zero-extended to 64 bits. An increment from all ones gives zero. At that clock edge the counter's status bit is set, in the same position it has in the global enable register.
- R6: The status register (address 8) keeps each overflow bit set until a write to the clear register (address 9) has a 1 in that bit position. An overflow in the same cycle as the clear leaves the bit set.
- R7: `irq_o` is high for exactly the one cycle after the clock edge at which an interrupt-enabled counter wraps. Several wraps at the same edge give one pulse.
- R8: A write to a counter's address replaces that counter's value and overrides any increment in the same cycle.
- R9: Status bit 63 sets when a write to address 5, 6 or 7 changes the stored value. Writing a 1 to clear-register bit 63 clears it, and a change in the same cycle wins over the clear.
- R10: Writes to address 8 and to addresses 10 to 15 are ignored. Reads of address 9 and of addresses 10 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_i | input | 2 | Current privilege ring (0 to 3) |
| evt_gp_i | input | 2 | Event pulses for the general counters |
| evt_fx_i | input | 3 | Event pulses for the fixed counters |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 64 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 64 | Combinational read data |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
Every piece of state in this block can be read back, so a wrong counter value, control field or status flag is visible at the read port in the first cycle after the edge that corrupted it. A counter error never corrects itself: the wrong value stays until that counter is written again. An error in the wrap detection or interrupt gating appears at `irq_o` and in the status register in the same cycle that the wrapped counter reads zero. Counters preloaded close to all ones make these wraps happen within a few cycles.

// File: rtl/pmu_pkg.sv
`timescale 1ns/100ps
// Shared helpers for the event counter unit.
// Assumes general counters take the low bits of the global registers and
// fixed counters start at a fixed base bit.
package pmu_pkg;

    // Bit position of counter idx inside the global enable/status registers.
    function automatic int unsigned glob_pos(input int unsigned idx,
                                             input int unsigned n_gp,
                                             input int unsigned fx_base);
        return (idx < n_gp) ? idx : fx_base + idx - n_gp;
    endfunction

endpackage

// File: rtl/pmu_counter.sv
`timescale 1ns/100ps
// One event counter: a register write loads it, a qualified event increments it.
// Assumes inc_i is already gated by the privilege and global enables.
// wrap_o is combinational and marks the cycle whose increment rolls over to zero.
module pmu_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // A write suppresses both the increment and the wrap flag.
    assign wrap_o = inc_i && !wr_i && (cnt_q == CNT_MAX);
    assign cnt_o  = cnt_q;

    // Counter register: write has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_i)   cnt_q <= wr_data_i;
        else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n) wrap_o |=> (cnt_q == '0)); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) wr_i |=> (cnt_q == $past(wr_data_i))); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!wr_i && !inc_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/pmu_event_gate.sv
`timescale 1ns/100ps
// Qualifies raw event pulses. General counters need their local enable and
// global bit. Fixed counters also need the ring-0 or ring>0 enable that
// matches the current ring.
// Assumes counter order: general counters first, then fixed counters.
module pmu_event_gate #(
    parameter int NUM_GP = 2,
    parameter int NUM_FX = 3,
    localparam int NUM_CNT = NUM_GP + NUM_FX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CNT-1:0]  evt_i,
    input  logic [1:0]          ring_i,
    input  logic [2*NUM_FX-1:0] fx_ren_i,
    input  logic [NUM_GP-1:0]   gp_en_i,
    input  logic [NUM_CNT-1:0]  glob_en_i,
    output logic [NUM_CNT-1:0]  inc_o
);
    logic at_ring0;

    assign at_ring0 = (ring_i == 2'd0);

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        // General counter: plain local enable ANDed with the global bit.
        assign inc_o[g] = evt_i[g] && gp_en_i[g] && glob_en_i[g];
    end

    for (genvar f = 0; f < NUM_FX; f++) begin : g_fx
        logic ring_ok;
        // Fixed counter: pick the enable that matches the current ring.
        assign ring_ok = at_ring0 ? fx_ren_i[2*f] : fx_ren_i[2*f+1];
        assign inc_o[NUM_GP+f] = evt_i[NUM_GP+f] && ring_ok && glob_en_i[NUM_GP+f];

        AST_RING0_FILTER: assert property (@(posedge clk) disable iff (!rst_n) (at_ring0 && inc_o[NUM_GP+f]) |-> fx_ren_i[2*f]); // R2
        AST_RINGN_FILTER: assert property (@(posedge clk) disable iff (!rst_n) (!at_ring0 && inc_o[NUM_GP+f]) |-> fx_ren_i[2*f+1]); // R2
    end

    AST_GLOBAL_GATES: assert property (@(posedge clk) disable iff (!rst_n) ((inc_o & ~glob_en_i) == '0)); // R4

endmodule

// File: rtl/pmu_ovf_status.sv
`timescale 1ns/100ps
// Holds the sticky overflow flags and the control-change flag, and produces
// the registered interrupt pulse.
// Assumes wrap_i pulses for one cycle per rollover. A set wins over a clear
// that arrives in the same cycle.
module pmu_ovf_status #(
    parameter int NUM_CNT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] wrap_i,
    input  logic [NUM_CNT-1:0] irq_en_i,
    input  logic               clr_wr_i,
    input  logic [NUM_CNT-1:0] clr_mask_i,
    input  logic               clr_sticky_i,
    input  logic               ctl_change_i,
    output logic [NUM_CNT-1:0] status_o,
    output logic               sticky_o,
    output logic               irq_o
);
    logic [NUM_CNT-1:0] status_q;
    logic               sticky_q;
    logic               irq_q;
    logic [NUM_CNT-1:0] clr_eff;

    assign clr_eff = clr_wr_i ? clr_mask_i : '0;

    // Overflow flags: clear first, then OR in new wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | wrap_i;
    end

    // Control-change flag: a change beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                        sticky_q <= 1'b0;
        else if (ctl_change_i)             sticky_q <= 1'b1;
        else if (clr_wr_i && clr_sticky_i) sticky_q <= 1'b0;
    end

    // Interrupt pulse: one cycle, merged over all counters.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(wrap_i & irq_en_i);
    end

    assign status_o = status_q;
    assign sticky_o = sticky_q;
    assign irq_o    = irq_q;

    AST_OVF_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) (|wrap_i) |=> ((status_q & $past(wrap_i)) == $past(wrap_i))); // R5
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !clr_wr_i |=> ((status_q & $past(status_q)) == $past(status_q))); // R6
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> $past(|(wrap_i & irq_en_i))); // R7
    AST_STICKY_SETS: assert property (@(posedge clk) disable iff (!rst_n) ctl_change_i |=> sticky_q); // R9

endmodule

// File: rtl/pmu_counter_unit.sv
`timescale 1ns/100ps
// Event counter unit: general and fixed counters, control and global enable
// registers, overflow status and an interrupt pulse.
// Assumes one register write per cycle and a combinational read port.
// Address map: counters 0..NUM_CNT-1, then fixed ctl, general ctl, global
// enable, status, clear.
module pmu_counter_unit
    import pmu_pkg::*;
#(
    parameter int NUM_GP         = 2,
    parameter int NUM_FX         = 3,
    parameter int CNT_W          = 48,
    parameter int DATA_W         = 64,
    parameter int ADDR_W         = 4,
    parameter int FX_GLOBAL_BASE = 32,
    parameter int STICKY_BIT     = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ring_i,
    input  logic [NUM_GP-1:0] evt_gp_i,
    input  logic [NUM_FX-1:0] evt_fx_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam int NUM_CNT  = NUM_GP + NUM_FX;
    localparam int FXCTL_W  = 4 * NUM_FX;
    localparam int GPCTL_W  = 2 * NUM_GP;
    localparam logic [ADDR_W-1:0] A_FXCTL = ADDR_W'(NUM_CNT);
    localparam logic [ADDR_W-1:0] A_GPCTL = ADDR_W'(NUM_CNT + 1);
    localparam logic [ADDR_W-1:0] A_GLOB  = ADDR_W'(NUM_CNT + 2);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(NUM_CNT + 3);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(NUM_CNT + 4);

    logic [FXCTL_W-1:0]  fx_ctl_q;
    logic [GPCTL_W-1:0]  gp_ctl_q;
    logic [NUM_CNT-1:0]  glob_q;
    logic [NUM_CNT-1:0]  glob_wr_val;
    logic [NUM_CNT-1:0]  evt, inc, wrap, cnt_wr, irq_en, status;
    logic [2*NUM_FX-1:0] fx_ren;
    logic [CNT_W-1:0]    cnt [NUM_CNT];
    logic                sticky, ctl_change, clr_wr;

    assign evt    = {evt_fx_i, evt_gp_i};
    assign clr_wr = wr_en_i && (wr_addr_i == A_CLR);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        // Pick this counter's bit out of a global-layout write word.
        assign glob_wr_val[i] = wr_data_i[glob_pos(i, NUM_GP, FX_GLOBAL_BASE)];
        assign cnt_wr[i]      = wr_en_i && (wr_addr_i == ADDR_W'(i));

        pmu_counter #(.CNT_W(CNT_W)) u_counter (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (cnt_wr[i]),
            .wr_data_i (wr_data_i[CNT_W-1:0]),
            .inc_i     (inc[i]),
            .cnt_o     (cnt[i]),
            .wrap_o    (wrap[i])
        );
    end

    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_ien
        assign irq_en[g] = gp_ctl_q[NUM_GP+g];
    end

    for (genvar f = 0; f < NUM_FX; f++) begin : g_fx_fields
        assign irq_en[NUM_GP+f] = fx_ctl_q[4*f+3];
        assign fx_ren[2*f +: 2] = fx_ctl_q[4*f +: 2];
    end

    // Control registers: loaded when their address is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fx_ctl_q <= '0;
            gp_ctl_q <= '0;
            glob_q   <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == A_FXCTL) fx_ctl_q <= wr_data_i[FXCTL_W-1:0];
            if (wr_addr_i == A_GPCTL) gp_ctl_q <= wr_data_i[GPCTL_W-1:0];
            if (wr_addr_i == A_GLOB)  glob_q   <= glob_wr_val;
        end
    end

    // Flag a control write that changes the stored value.
    always_comb begin
        ctl_change = 1'b0;
        if (wr_en_i) begin
            if (wr_addr_i == A_FXCTL && wr_data_i[FXCTL_W-1:0] != fx_ctl_q) ctl_change = 1'b1;
            if (wr_addr_i == A_GPCTL && wr_data_i[GPCTL_W-1:0] != gp_ctl_q) ctl_change = 1'b1;
            if (wr_addr_i == A_GLOB  && glob_wr_val != glob_q)              ctl_change = 1'b1;
        end
    end

    pmu_event_gate #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .ring_i    (ring_i),
        .fx_ren_i  (fx_ren),
        .gp_en_i   (gp_ctl_q[NUM_GP-1:0]),
        .glob_en_i (glob_q),
        .inc_o     (inc)
    );

    pmu_ovf_status #(.NUM_CNT(NUM_CNT)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .wrap_i       (wrap),
        .irq_en_i     (irq_en),
        .clr_wr_i     (clr_wr),
        .clr_mask_i   (glob_wr_val),
        .clr_sticky_i (wr_data_i[STICKY_BIT]),
        .ctl_change_i (ctl_change),
        .status_o     (status),
        .sticky_o     (sticky),
        .irq_o        (irq_o)
    );

    // Read mux: counters, control words and expanded global views.
    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (rd_addr_i == ADDR_W'(k)) rd_data_o = DATA_W'(cnt[k]);
        end
        if (rd_addr_i == A_FXCTL) rd_data_o = DATA_W'(fx_ctl_q);
        if (rd_addr_i == A_GPCTL) rd_data_o = DATA_W'(gp_ctl_q);
        if (rd_addr_i == A_GLOB) begin
            for (int k = 0; k < NUM_CNT; k++) rd_data_o[glob_pos(k, NUM_GP, FX_GLOBAL_BASE)] = glob_q[k];
        end
        if (rd_addr_i == A_STAT) begin
            for (int k = 0; k < NUM_CNT; k++) rd_data_o[glob_pos(k, NUM_GP, FX_GLOBAL_BASE)] = status[k];
            rd_data_o[STICKY_BIT] = sticky;
        end
    end

    AST_FXCTL_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_i && wr_addr_i == A_FXCTL) |=> (fx_ctl_q == $past(wr_data_i[FXCTL_W-1:0]))); // R2
    AST_GPCTL_LOADS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_i && wr_addr_i == A_GPCTL) |=> (gp_ctl_q == $past(wr_data_i[GPCTL_W-1:0]))); // R3

endmodule

// File: tb/test_pmu_counter_unit.sv
`timescale 1ns/100ps
// Self-checking bench: directed corner cases, then seeded random stimulus,
// compared against a reference model kept in bench functions.
module test_pmu_counter_unit;
    localparam logic [47:0] MAX = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ring_i = '0;
    logic [1:0]  evt_gp_i = '0;
    logic [2:0]  evt_fx_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [63:0] wr_data_i = '0;
    logic [3:0]  rd_addr_i = '0;
    logic [63:0] rd_data_o;
    logic        irq_o;

    int n_checks = 0;
    int n_err = 0;

    // Reference model state
    logic [47:0] m_cnt [5];
    logic [11:0] m_fx;
    logic [3:0]  m_gp;
    logic [4:0]  m_glob, m_stat;
    logic        m_sticky, m_irq;

    always #10 clk = ~clk;

    pmu_counter_unit i_pmu_counter_unit (
        .clk(clk), .rst_n(rst_n), .ring_i(ring_i), .evt_gp_i(evt_gp_i),
        .evt_fx_i(evt_fx_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o)
    );

    function automatic logic [63:0] expand(input logic [4:0] v);
        logic [63:0] r = '0;
        r[1:0]   = v[1:0];
        r[34:32] = v[4:2];
        return r;
    endfunction

    function automatic logic [63:0] exp_read(input int a);
        if (a < 5)  return {16'b0, m_cnt[a]};
        if (a == 5) return {52'b0, m_fx};
        if (a == 6) return {60'b0, m_gp};
        if (a == 7) return expand(m_glob);
        if (a == 8) return expand(m_stat) | {m_sticky, 63'b0};
        return '0;
    endfunction

    function automatic string tag_of(input int a);
        if (a < 5)  return "R5";
        if (a == 5) return "R2";
        if (a == 6) return "R3";
        if (a == 7) return "R4";
        if (a == 8) return "R6 R9";
        return "R10";
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string lbl);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s (%s): actual %h expected %h", tag, lbl, act, exp);
        end
    endtask

    task automatic check_all(input string lbl);
        for (int a = 0; a < 11; a++) begin
            rd_addr_i = 4'((a == 10) ? 13 : a);
            #0.5;
            chk(tag_of(a), rd_data_o, exp_read(a), lbl);
        end
        chk("R7", {63'b0, irq_o}, {63'b0, m_irq}, lbl);
    endtask

    // Reference next state, computed from the requirements.
    task automatic predict(input logic [4:0] evt, input logic [1:0] ring, input logic we,
                           input logic [3:0] wa, input logic [63:0] wd);
        logic [4:0] inc, wrap, ien, gnew;
        logic loc, cw, chg;
        ien = {m_fx[11], m_fx[7], m_fx[3], m_gp[3], m_gp[2]};
        for (int k = 0; k < 5; k++) begin
            loc = (k < 2) ? m_gp[k] : ((ring == 2'd0) ? m_fx[4*(k-2)] : m_fx[4*(k-2)+1]);
            inc[k] = evt[k] && loc && m_glob[k];
            cw = we && (wa == 4'(k));
            wrap[k] = inc[k] && !cw && (m_cnt[k] == MAX);
            if (cw)          m_cnt[k] = wd[47:0];
            else if (inc[k]) m_cnt[k] = m_cnt[k] + 48'd1;
        end
        m_irq = |(wrap & ien);
        chg = 1'b0;
        gnew = {wd[34:32], wd[1:0]};
        if (we && wa == 4'd5) begin chg = (wd[11:0] != m_fx); m_fx = wd[11:0]; end
        if (we && wa == 4'd6) begin chg = (wd[3:0] != m_gp);  m_gp = wd[3:0]; end
        if (we && wa == 4'd7) begin chg = (gnew != m_glob);   m_glob = gnew; end
        if (we && wa == 4'd9) m_stat = m_stat & ~gnew;
        m_stat = m_stat | wrap;
        if (chg) m_sticky = 1'b1;
        else if (we && wa == 4'd9 && wd[63]) m_sticky = 1'b0;
    endtask

    task automatic step(input logic [4:0] evt, input logic [1:0] ring, input logic we,
                        input logic [3:0] wa, input logic [63:0] wd, input string lbl);
        check_all(lbl);
        evt_gp_i = evt[1:0]; evt_fx_i = evt[4:2]; ring_i = ring;
        wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
        predict(evt, ring, we, wa, wd);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        for (int k = 0; k < 5; k++) m_cnt[k] = '0;
        m_fx = '0; m_gp = '0; m_glob = '0; m_stat = '0; m_sticky = 1'b0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, then configuration; R9 sticky set by a change
        step(5'h1F, 2'd0, 1'b1, 4'd7, '1, "R1 reset state / R4 reserved bits");
        step(5'h00, 2'd0, 1'b1, 4'd9, 64'h8000_0000_0000_0000, "R9 sticky clear");
        step(5'h00, 2'd0, 1'b1, 4'd5, 64'hB21, "R2 fixed ctl load");
        step(5'h00, 2'd0, 1'b1, 4'd5, 64'hB21, "R9 unchanged write keeps clear");
        step(5'h00, 2'd0, 1'b1, 4'd6, 64'h5, "R3 general ctl load");
        // R2 ring filtering at every ring
        for (int r = 0; r < 4; r++)
            for (int n = 0; n < 3; n++) step(5'h1F, 2'(r), 1'b0, 4'd0, '0, "R2 ring filter");
        // R4 global gate: only fixed counter 1 enabled globally
        step(5'h00, 2'd0, 1'b1, 4'd7, 64'h2_0000_0000, "R4 global AND");
        for (int n = 0; n < 3; n++) step(5'h1F, 2'd2, 1'b0, 4'd0, '0, "R4 global AND");
        step(5'h00, 2'd0, 1'b1, 4'd7, 64'h7_0000_0003, "R4 global restore");
        // R8 write beats increment
        step(5'h1F, 2'd1, 1'b1, 4'd2, 64'd100, "R8 write beats increment");
        step(5'h1F, 2'd0, 1'b1, 4'd4, 64'd7, "R8 write beats increment");
        // R5 wrap without interrupt (fixed 0 has no irq bit)
        step(5'h00, 2'd0, 1'b1, 4'd2, {16'b0, MAX}, "R5 preload");
        step(5'h04, 2'd0, 1'b0, 4'd0, '0, "R5 wrap");
        // R7 simultaneous wraps give one pulse
        step(5'h00, 2'd0, 1'b1, 4'd4, {16'b0, MAX}, "R7 preload");
        step(5'h00, 2'd0, 1'b1, 4'd0, {16'b0, MAX}, "R7 preload");
        step(5'h11, 2'd0, 1'b0, 4'd0, '0, "R7 simultaneous wrap");
        step(5'h00, 2'd0, 1'b0, 4'd0, '0, "R7 pulse width");
        // R6 set beats clear in the same cycle
        step(5'h00, 2'd0, 1'b1, 4'd0, {16'b0, MAX}, "R6 preload");
        step(5'h01, 2'd0, 1'b1, 4'd9, 64'h1, "R6 set beats clear");
        step(5'h00, 2'd0, 1'b1, 4'd9, 64'h4_0000_0000, "R6 partial clear");
        step(5'h00, 2'd0, 1'b1, 4'd9, '1, "R6 full clear");
        // R10 ignored writes
        step(5'h00, 2'd0, 1'b1, 4'd8, '1, "R10 status write ignored");
        step(5'h00, 2'd0, 1'b1, 4'd13, '1, "R10 unused write ignored");
        // Seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [3:0]  wa;
            logic [63:0] wd;
            wa = 4'($urandom % 12);
            wd = {$urandom, $urandom};
            if (wa < 4'd5 && ($urandom % 2) == 0) wd = {16'b0, MAX - 48'($urandom % 3)};
            step(5'($urandom), 2'($urandom), ($urandom % 6) == 0, wa, wd, "random");
        end
        check_all("final");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule